// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block sits between a small processor core and an asynchronous external bus that carries memories and I/O devices. The core hands it one access at a time: a data read, a data write, or either of these aimed at I/O space. The sequencer drives the address, a one-of-N active-low chip select, an I/O-space flag, an active-low output enable, an active-low write enable, write data with its drive enable, and captures the read data. Every access follows the same sequence: an address clock, a strobe window of `STRB_CLKS` clocks, and one hold clock. Memory and I/O cycles share this sequence.

Instruction fetches may start speculatively. The core raises `fetch_go` with a fetch target and the bus shows that address and chip select for one clock with both strobes off. If the core presents a data request in that clock, the fetch is dropped. The address and chip select then move to the data target, and the strobe starts one clock later. Otherwise the speculative clock becomes the address clock of the fetch, and output enable falls on the next clock. In every case a strobe begins exactly one clock after the final, stable address and chip select appear.

All pins are registered. Completion is reported by a one-clock `done` pulse in the hold clock, with `rdata` holding the value sampled on the last strobe clock of a read or fetch.

Top module: `xbus_seq`

## Requirements
- R1: After reset and whenever no access is in progress, `bus_cs_n` is all ones, `bus_oe_n` and `bus_we_n` are 1, `bus_dout_en` is 0 and `req_ready` is 1.
- R2: A request taken while `req_ready` is high (with `req_valid` at a clock edge) drives `bus_addr` = `req_addr` in the next clock. In that clock, bit `req_cs` of `bus_cs_n` is 0 and all other bits are 1, both strobes are 1 and `req_ready` is 0.
- R3: For a read (`req_write`=0), `bus_oe_n` is 0 for exactly `STRB_CLKS` clocks, starting the clock after the address clock. `bus_we_n` stays 1, and address and chip select do not change.
- R4: For a write (`req_write`=1), `bus_we_n` is 0 and `bus_dout_en` is 1 with `bus_dout` = `req_wdata` for exactly `STRB_CLKS` clocks, starting the clock after the address clock. `bus_oe_n` stays 1.
- R5: After the strobe window comes one hold clock. In it both strobes are 1, address and chip select are unchanged, `bus_dout_en` stays 1 for writes and `req_ready` is 1. A request presented in the hold clock goes straight to its own address clock; with no request, the bus is idle next.
- R6: `done` is 1 for exactly the hold clock of every access. For reads and fetches, `rdata` then equals `bus_din` as sampled on the last strobe clock.
- R7: I/O accesses (`req_io`=1) follow the same timing as memory accesses, with `bus_io` at 1 from the address clock through the hold clock.
- R8: `fetch_go` taken while `req_ready` is high and `req_valid` is low gives one speculative clock. In it `bus_addr` = `fetch_addr`, chip select `fetch_cs` is low, both strobes are 1 and `req_ready` is 1.
- R9: With no `req_valid` in the speculative clock, that clock serves as the fetch's address clock. `bus_oe_n` falls on the next clock with the fetch address unchanged, and the fetch completes as a read.
- R10: With `req_valid` in the speculative clock, the fetch is abandoned. Next clock shows the data request's address and chip select with both strobes still 1, and its strobe begins the clock after. No strobe is ever low in a speculative clock.
- R11: When `req_valid` and `fetch_go` are both high at the same accepting edge, the data request wins and no speculative clock occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Data access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | AW | Data access address |
| req_cs | input | CSW | Index of chip select for data access |
| req_wdata | input | DW | Write data |
| fetch_go | input | 1 | Start a speculative instruction fetch |
| fetch_addr | input | AW | Fetch address |
| fetch_cs | input | CSW | Index of chip select for fetch |
| req_ready | output | 1 | Request or fetch start is taken at the next edge |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Read data of the completed read or fetch |
| bus_addr | output | AW | External address |
| bus_cs_n | output | NCS | Active-low chip selects |
| bus_io | output | 1 | I/O-space flag |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable |
| bus_dout | output | DW | Write data to the bus |
| bus_dout_en | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | DW | Read data from the bus |

## Verification
A phase register stuck or advanced early shows up in the very next clock. It appears as a strobe that falls together with an address change, a strobe window of the wrong length, or a chip select that drops before the hold clock. A target register loaded at the wrong time shows up one clock after the abort decision, as the fetch address left on the bus while the data strobe runs. A misaligned read-capture enable shows only at `done`, as `rdata` taken from the wrong clock. It is therefore checked against a bus model whose data depends on the address.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SPEC,
    PH_ADDR,
    PH_STRB,
    PH_HOLD
  } xbus_phase_e;
endpackage

// File: rtl/xbus_phase_fsm.sv
module xbus_phase_fsm
  import xbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CSW       = 2,
  parameter int STRB_CLKS = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic           req_io,
  input  logic [AW-1:0]  req_addr,
  input  logic [CSW-1:0] req_cs,
  input  logic [DW-1:0]  req_wdata,
  input  logic           fetch_go,
  input  logic [AW-1:0]  fetch_addr,
  input  logic [CSW-1:0] fetch_cs,
  output xbus_phase_e    phase_d,
  output logic           req_ready,
  output logic           strb_last,
  output logic           cur_write,
  output logic [AW-1:0]  t_addr_d,
  output logic [CSW-1:0] t_cs_d,
  output logic           t_io_d,
  output logic           t_write_d,
  output logic [DW-1:0]  t_wdata_d
);
  localparam int CNTW = (STRB_CLKS > 1) ? $clog2(STRB_CLKS) : 1;

  xbus_phase_e    phase_q;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [AW-1:0]  t_addr_q;
  logic [CSW-1:0] t_cs_q;
  logic           t_io_q, t_write_q;
  logic [DW-1:0]  t_wdata_q;

  assign strb_last = (phase_q == PH_STRB) && (cnt_q == CNTW'(STRB_CLKS - 1));
  assign req_ready = (phase_q == PH_IDLE) || (phase_q == PH_HOLD) || (phase_q == PH_SPEC);
  assign cur_write = t_write_q;

  always_comb begin
    phase_d   = phase_q;
    t_addr_d  = t_addr_q;
    t_cs_d    = t_cs_q;
    t_io_d    = t_io_q;
    t_write_d = t_write_q;
    t_wdata_d = t_wdata_q;
    case (phase_q)
      PH_IDLE, PH_HOLD, PH_SPEC: begin
        if (req_valid) begin
          phase_d   = PH_ADDR;
          t_addr_d  = req_addr;
          t_cs_d    = req_cs;
          t_io_d    = req_io;
          t_write_d = req_write;
          t_wdata_d = req_wdata;
        end else if (phase_q == PH_SPEC) begin
          phase_d = PH_STRB;
        end else if (fetch_go) begin
          phase_d   = PH_SPEC;
          t_addr_d  = fetch_addr;
          t_cs_d    = fetch_cs;
          t_io_d    = 1'b0;
          t_write_d = 1'b0;
        end else begin
          phase_d = PH_IDLE;
        end
      end
      PH_ADDR: phase_d = PH_STRB;
      PH_STRB: phase_d = strb_last ? PH_HOLD : PH_STRB;
      default: phase_d = PH_IDLE;
    endcase
  end

  assign cnt_d = (phase_q == PH_STRB && !strb_last) ? cnt_q + 1'b1 : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      t_addr_q  <= '0;
      t_cs_q    <= '0;
      t_io_q    <= 1'b0;
      t_write_q <= 1'b0;
      t_wdata_q <= '0;
    end else begin
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
      t_addr_q  <= t_addr_d;
      t_cs_q    <= t_cs_d;
      t_io_q    <= t_io_d;
      t_write_q <= t_write_d;
      t_wdata_q <= t_wdata_d;
    end
  end
endmodule

// File: rtl/xbus_pin_regs.sv
module xbus_pin_regs
  import xbus_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int NCS = 4,
  parameter int CSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  xbus_phase_e    phase_d,
  input  logic [AW-1:0]  t_addr_d,
  input  logic [CSW-1:0] t_cs_d,
  input  logic           t_io_d,
  input  logic           t_write_d,
  input  logic [DW-1:0]  t_wdata_d,
  output logic [AW-1:0]  bus_addr,
  output logic [NCS-1:0] bus_cs_n,
  output logic           bus_io,
  output logic           bus_oe_n,
  output logic           bus_we_n,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_dout_en
);
  logic active_d, strobe_d;
  logic [NCS-1:0] cs_n_r;

  assign active_d = (phase_d != PH_IDLE);
  assign strobe_d = (phase_d == PH_STRB);

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) cs_n_r[g] <= 1'b1;
      else     cs_n_r[g] <= !(active_d && (t_cs_d == CSW'(g)));
    end
  end
  assign bus_cs_n = cs_n_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr    <= '0;
      bus_io      <= 1'b0;
      bus_oe_n    <= 1'b1;
      bus_we_n    <= 1'b1;
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
    end else begin
      if (active_d) begin
        bus_addr <= t_addr_d;
        bus_dout <= t_wdata_d;
      end
      bus_io      <= active_d && t_io_d;
      bus_oe_n    <= !(strobe_d && !t_write_d);
      bus_we_n    <= !(strobe_d && t_write_d);
      bus_dout_en <= t_write_d && (strobe_d || phase_d == PH_HOLD);
    end
  end
endmodule

// File: rtl/xbus_rd_capture.sv
module xbus_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strb_last,
  input  logic          cur_write,
  input  logic [DW-1:0] bus_din,
  output logic          done,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= strb_last;
      if (strb_last && !cur_write) rdata <= bus_din;
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int NCS       = 4,
  parameter int STRB_CLKS = 1,
  localparam int CSW      = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic           req_io,
  input  logic [AW-1:0]  req_addr,
  input  logic [CSW-1:0] req_cs,
  input  logic [DW-1:0]  req_wdata,
  input  logic           fetch_go,
  input  logic [AW-1:0]  fetch_addr,
  input  logic [CSW-1:0] fetch_cs,
  output logic           req_ready,
  output logic           done,
  output logic [DW-1:0]  rdata,
  output logic [AW-1:0]  bus_addr,
  output logic [NCS-1:0] bus_cs_n,
  output logic           bus_io,
  output logic           bus_oe_n,
  output logic           bus_we_n,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_dout_en,
  input  logic [DW-1:0]  bus_din
);
  xbus_phase_e    phase_d;
  logic           strb_last, cur_write;
  logic [AW-1:0]  t_addr_d;
  logic [CSW-1:0] t_cs_d;
  logic           t_io_d, t_write_d;
  logic [DW-1:0]  t_wdata_d;

  xbus_phase_fsm #(.AW(AW), .DW(DW), .CSW(CSW), .STRB_CLKS(STRB_CLKS)) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
    .req_addr(req_addr), .req_cs(req_cs), .req_wdata(req_wdata),
    .fetch_go(fetch_go), .fetch_addr(fetch_addr), .fetch_cs(fetch_cs),
    .phase_d(phase_d), .req_ready(req_ready), .strb_last(strb_last),
    .cur_write(cur_write), .t_addr_d(t_addr_d), .t_cs_d(t_cs_d),
    .t_io_d(t_io_d), .t_write_d(t_write_d), .t_wdata_d(t_wdata_d)
  );

  xbus_pin_regs #(.AW(AW), .DW(DW), .NCS(NCS), .CSW(CSW)) u_pins (
    .clk(clk), .rst(rst), .phase_d(phase_d),
    .t_addr_d(t_addr_d), .t_cs_d(t_cs_d), .t_io_d(t_io_d),
    .t_write_d(t_write_d), .t_wdata_d(t_wdata_d),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_io(bus_io),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en)
  );

  xbus_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .strb_last(strb_last), .cur_write(cur_write),
    .bus_din(bus_din), .done(done), .rdata(rdata)
  );
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int AW  = 16,
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [AW-1:0]  bus_addr,
  input logic [NCS-1:0] bus_cs_n,
  input logic           bus_oe_n,
  input logic           bus_we_n,
  input logic           bus_dout_en,
  input logic           done
);
  AST_OE_AFTER_STABLE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_oe_n) |-> ($past(bus_addr) == bus_addr) && ($past(bus_cs_n) == bus_cs_n) && ($past(bus_cs_n) != '1)); // R3
  AST_WE_AFTER_STABLE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_we_n) |-> ($past(bus_addr) == bus_addr) && ($past(bus_cs_n) == bus_cs_n) && ($past(bus_cs_n) != '1)); // R4
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!bus_oe_n && !bus_we_n)); // R3
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe_n || !bus_we_n) |-> ($countones(~bus_cs_n) == 1)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_cs_n == '1) |-> (bus_oe_n && bus_we_n && !bus_dout_en)); // R1
  AST_DRIVE_WITH_WE: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> bus_dout_en); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_oe_n) || $rose(bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_cs_n))); // R5
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    done |-> (bus_oe_n && bus_we_n && (!$past(bus_oe_n) || !$past(bus_we_n)))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
endmodule

bind xbus_seq xbus_seq_chk #(.AW(AW), .NCS(NCS)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
  .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_dout_en(bus_dout_en),
  .done(done)
);

// File: tb/sim_xbus_seq.sv
module sim_xbus_seq;
  localparam int AW = 16, DW = 8, NCS = 4, CSW = 2, SCLK = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [AW-1:0] req_addr = '0, fetch_addr = '0;
  logic [CSW-1:0] req_cs = '0, fetch_cs = '0;
  logic [DW-1:0] req_wdata = '0;
  logic fetch_go = 1'b0;
  logic req_ready, done, bus_io, bus_oe_n, bus_we_n, bus_dout_en;
  logic [DW-1:0] rdata, bus_dout, bus_din;
  logic [AW-1:0] bus_addr;
  logic [NCS-1:0] bus_cs_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit exp_chk_q[$];
  logic [DW-1:0] exp_dat_q[$];

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign bus_din = memf(bus_addr);

  xbus_seq #(.AW(AW), .DW(DW), .NCS(NCS), .STRB_CLKS(SCLK)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_cs(req_cs),
    .req_wdata(req_wdata), .fetch_go(fetch_go), .fetch_addr(fetch_addr),
    .fetch_cs(fetch_cs), .req_ready(req_ready), .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_io(bus_io),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din)
  );

  function automatic logic [NCS-1:0] csn(input logic [CSW-1:0] c);
    return ~(NCS'(1) << c);
  endfunction

  task automatic check(input string rq, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  // {cs_n, addr, io, oe_n, we_n, dout_en, ready}
  task automatic check_pins(input string rq, input logic [NCS-1:0] cn, input logic [AW-1:0] a,
                            input logic io, input logic oe, input logic we, input logic den,
                            input logic rdy);
    check(rq, 64'({bus_cs_n, bus_addr, bus_io, bus_oe_n, bus_we_n, bus_dout_en, req_ready}),
          64'({cn, a, io, oe, we, den, rdy}));
  endtask

  task automatic check_idle(input string rq);
    check(rq, 64'({bus_cs_n, bus_oe_n, bus_we_n, bus_dout_en, req_ready, bus_io}),
          64'({{NCS{1'b1}}, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}));
  endtask

  task automatic push_exp(input logic w, input logic [AW-1:0] a);
    exp_chk_q.push_back(!w);
    exp_dat_q.push_back(memf(a));
  endtask

  // strobe window, hold clock and optional idle clock; entered at the negedge of the address clock
  task automatic body(input string rq, input logic w, input logic io, input logic [AW-1:0] a,
                      input logic [CSW-1:0] c, input logic [DW-1:0] wd, input bit chain);
    for (int k = 0; k < SCLK; k++) begin
      @(negedge clk);
      check_pins(rq, csn(c), a, io, w, !w, w, 1'b0);
      if (w) check({rq, " dout R4"}, 64'(bus_dout), 64'(wd));
    end
    @(negedge clk);
    check_pins({rq, " hold R5"}, csn(c), a, io, 1'b1, 1'b1, w, 1'b1);
    check("done in hold R6", 64'(done), 64'd1);
    if (!chain) begin
      @(negedge clk);
      check_idle("idle after access R1");
      check("done single R6", 64'(done), 64'd0);
    end
  endtask

  task automatic do_access(input string rq, input logic w, input logic io, input logic [AW-1:0] a,
                           input logic [CSW-1:0] c, input logic [DW-1:0] wd, input bit chain);
    req_valid = 1'b1; req_write = w; req_io = io; req_addr = a; req_cs = c; req_wdata = wd;
    push_exp(w, a);
    @(negedge clk);
    req_valid = 1'b0; fetch_go = 1'b0;
    check_pins({rq, " addr clock R2"}, csn(c), a, io, 1'b1, 1'b1, 1'b0, 1'b0);
    body(rq, w, io, a, c, wd, chain);
  endtask

  task automatic spec_fetch(input logic [AW-1:0] fa, input logic [CSW-1:0] fc, input bit abort_it,
                            input logic w, input logic io, input logic [AW-1:0] a,
                            input logic [CSW-1:0] c, input logic [DW-1:0] wd);
    fetch_go = 1'b1; fetch_addr = fa; fetch_cs = fc;
    @(negedge clk);
    fetch_go = 1'b0;
    check_pins("spec clock R8", csn(fc), fa, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    if (abort_it) begin
      req_valid = 1'b1; req_write = w; req_io = io; req_addr = a; req_cs = c; req_wdata = wd;
      push_exp(w, a);
      @(negedge clk);
      req_valid = 1'b0;
      check_pins("retarget no strobe R10", csn(c), a, io, 1'b1, 1'b1, 1'b0, 1'b0);
      body("retargeted access R10", w, io, a, c, wd, 1'b0);
    end else begin
      push_exp(1'b0, fa);
      body("kept fetch R9", 1'b0, 1'b0, fa, fc, '0, 1'b0);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_chk_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected done got=1 exp=0");
      end else begin
        bit ck;
        logic [DW-1:0] ed;
        ck = exp_chk_q.pop_front();
        ed = exp_dat_q.pop_front();
        if (ck) check("rdata R6", 64'(rdata), 64'(ed));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("reset state R1");
    check("reset done R6", 64'(done), 64'd0);

    do_access("mem read R3", 1'b0, 1'b0, 16'h1234, 2'd1, 8'h00, 1'b0);
    do_access("mem write R4", 1'b1, 1'b0, 16'h00F0, 2'd2, 8'h3C, 1'b0);
    do_access("io read R7", 1'b0, 1'b1, 16'h0042, 2'd0, 8'h00, 1'b0);
    do_access("io write R7", 1'b1, 1'b1, 16'h0043, 2'd3, 8'hC5, 1'b1);
    do_access("back-to-back read R5", 1'b0, 1'b0, 16'hBEEF, 2'd2, 8'h00, 1'b0);

    spec_fetch(16'h8000, 2'd3, 1'b0, 1'b0, 1'b0, '0, '0, '0);
    spec_fetch(16'h8002, 2'd3, 1'b1, 1'b1, 1'b0, 16'h0101, 2'd0, 8'h96);
    spec_fetch(16'h8004, 2'd1, 1'b1, 1'b0, 1'b1, 16'h00A7, 2'd2, 8'h00);

    fetch_go = 1'b1; fetch_addr = 16'h9000; fetch_cs = 2'd3;
    do_access("priority R11", 1'b0, 1'b0, 16'h4321, 2'd1, 8'h00, 1'b0);

    repeat (3) @(negedge clk);
    check("all accesses completed R6", 64'(exp_chk_q.size()), 64'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL R1 watchdog expired got=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule